// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block supplies the word address for every cycle of a four-beat memory burst. When the active-low address-status strobe is sampled low, it captures an external word address. That address becomes the first beat. On each later clock edge where the advance control is high, the sequencer moves to the next beat. When advance is low, it holds the current beat, which is how wait states are inserted.

Only the two least significant address bits change during a burst. The upper bits keep the captured value, so every generated address stays inside the aligned group of four that the captured address belongs to. A static mode pin selects the order of the low two bits:
- **Linear order** adds the beat count to the start offset and wraps modulo four.
- **Interleaved order** XORs the start offset with the beat count.

The outputs are the current word address and the beat index within the burst. After the fourth beat the beat index wraps to zero, so continued advancing walks through the same group of four again. A new strobe abandons any burst in progress.

Top module: `burstSeq`

## Requirements
- R1: While reset is asserted (rstN low), wordAddr and beatIdx are both zero.
- R2: A clock edge with adsN low captures extAddr. From the following cycle wordAddr equals the captured address and beatIdx is 0, whatever the mode.
- R3: A clock edge with adsN high and advance high raises beatIdx by one, modulo four.
- R4: A clock edge with adsN high and advance low leaves beatIdx and wordAddr unchanged.
- R5: wordAddr bits above bit 1 equal the captured address for every beat, until the next capture.
- R6: With modeInterleave low (linear), the low two bits of wordAddr are (start + beatIdx) mod 4. For example, start 01 gives 01, 10, 11, 00 and start 11 gives 11, 00, 01, 10.
- R7: With modeInterleave high (interleaved), the low two bits of wordAddr are start XOR beatIdx. For example, start 10 gives 10, 11, 00, 01 and start 11 gives 11, 10, 01, 00.
- R8: Advancing from beatIdx 3 returns beatIdx to 0 and the low bits to the start offset, so the group of four repeats.
- R9: adsN low takes priority over advance. It aborts a burst in progress, reloads extAddr and returns beatIdx to 0 on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| extAddr | input | ADDR_W | External word address, captured when adsN is low |
| adsN | input | 1 | Active-low address-status strobe: capture and restart |
| advance | input | 1 | Step to the next beat when high; hold when low |
| modeInterleave | input | 1 | 1 = interleaved order, 0 = linear order; held static |
| wordAddr | output | ADDR_W | Current beat's word address |
| beatIdx | output | 2 | Beat index within the burst, 0 to 3 |

## Verification
The hardest situations to reach from the ports involve a capture arriving while advance is also high. This happens both mid-burst and right at the wrap point, where a wrong priority would leave beatIdx at a non-zero value. The stimulus therefore reloads with advance held high partway through a burst. Between loads it also mixes hold cycles into advancing sequences. This is done for every start offset in both modes, with upper address bits that differ between bursts. A mis-wired priority, a wrong wrap or a leaked carry into the upper bits would each produce a scoreboard mismatch.

// File: rtl/burstSeqPkg.sv
package burstSeqPkg;
  // Strobes that the control issues to the datapath each cycle.
  typedef struct packed {
    logic loadAddr;  // capture the external address, restart burst
    logic stepBeat;  // move to the next beat
  } seqStrobes_t;
endpackage

// File: rtl/burstSeqCtrl.sv
module burstSeqCtrl
  import burstSeqPkg::*;
#(
  parameter int BURST_LEN = 4,
  localparam int OFS_W = $clog2(BURST_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             adsN,
  input  logic             advance,
  output seqStrobes_t      strobes,
  output logic [OFS_W-1:0] beat
);

  // Capture wins over advance.
  always_comb begin
    strobes.loadAddr = ~adsN;
    strobes.stepBeat = adsN & advance;
  end

  // BURST_LEN is a power of two, so the counter wraps naturally.
  always_ff @(posedge clk) begin
    if (!rstN)                 beat <= '0;
    else if (strobes.loadAddr) beat <= '0;
    else if (strobes.stepBeat) beat <= beat + OFS_W'(1);
  end

  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (adsN && advance) |=> beat == OFS_W'($past(beat) + OFS_W'(1)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (adsN && !advance) |=> $stable(beat));

  p_load_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    !adsN |=> beat == '0);

endmodule

// File: rtl/burstSeqPath.sv
module burstSeqPath
  import burstSeqPkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int BURST_LEN = 4,
  localparam int OFS_W = $clog2(BURST_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [OFS_W-1:0]  beat,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              modeInterleave,
  output logic [ADDR_W-1:0] wordAddr
);

  logic [ADDR_W-1:0] baseAddr;
  logic [OFS_W-1:0]  startOfs;
  logic [OFS_W-1:0]  linOfs;
  logic [OFS_W-1:0]  intOfs;
  logic [OFS_W-1:0]  curOfs;

  always_ff @(posedge clk) begin
    if (!rstN)                 baseAddr <= '0;
    else if (strobes.loadAddr) baseAddr <= extAddr;
  end

  assign startOfs = baseAddr[OFS_W-1:0];

  // Both orderings are built; the static mode pin selects one.
  always_comb begin
    linOfs = startOfs + beat;
    intOfs = startOfs ^ beat;
    curOfs = modeInterleave ? intOfs : linOfs;
  end

  assign wordAddr = {baseAddr[ADDR_W-1:OFS_W], curOfs};

  p_load_base_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadAddr |=> wordAddr == $past(extAddr));

  p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadAddr |=> $stable(wordAddr[ADDR_W-1:OFS_W]));

  p_linear_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepBeat && !modeInterleave) |=>
      (modeInterleave || wordAddr[OFS_W-1:0] ==
        OFS_W'($past(wordAddr[OFS_W-1:0]) + OFS_W'(1))));

endmodule

// File: rtl/burstSeq.sv
module burstSeq
  import burstSeqPkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int BURST_LEN = 4,
  localparam int OFS_W = $clog2(BURST_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              adsN,
  input  logic              advance,
  input  logic              modeInterleave,
  output logic [ADDR_W-1:0] wordAddr,
  output logic [OFS_W-1:0]  beatIdx
);

  seqStrobes_t      strobes;
  logic [OFS_W-1:0] beat;

  burstSeqCtrl #(.BURST_LEN(BURST_LEN)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .adsN    (adsN),
    .advance (advance),
    .strobes (strobes),
    .beat    (beat)
  );

  burstSeqPath #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) uPath (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .beat           (beat),
    .extAddr        (extAddr),
    .modeInterleave (modeInterleave),
    .wordAddr       (wordAddr)
  );

  assign beatIdx = beat;

  p_reset_zero_r1: assert property (@(posedge clk)
    $past(!rstN) |-> (wordAddr == '0 && beatIdx == '0));

endmodule

// File: tb/tb_burstSeq.sv
module tb_burstSeq;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] extAddr = '0;
  logic          adsN = 1'b1;
  logic          advance = 1'b0;
  logic          modeInterleave = 1'b0;
  logic [AW-1:0] wordAddr;
  logic [1:0]    beatIdx;

  int total = 0;
  int bad = 0;
  int cycle = 0;
  bit finished = 0;

  typedef struct {
    logic [AW-1:0] addr;
    logic [1:0]    beat;
    string         tag;
    int            due;
  } exp_t;
  exp_t q[$];

  logic [AW-1:0] mBase = '0;
  logic [1:0]    mBeat = '0;

  burstSeq #(.ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .extAddr(extAddr), .adsN(adsN),
    .advance(advance), .modeInterleave(modeInterleave),
    .wordAddr(wordAddr), .beatIdx(beatIdx)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  function automatic logic [1:0] refOfs(logic [1:0] s, logic [1:0] b, logic m);
    return m ? (s ^ b) : (s + b);
  endfunction

  task automatic check(string tag, logic [AW-1:0] ea, logic [1:0] eb);
    total++;
    if (wordAddr !== ea || beatIdx !== eb) begin
      bad++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, wordAddr, beatIdx, ea, eb);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the expected result.
  task automatic drive(bit ads, bit adv, logic [AW-1:0] a, string tag);
    exp_t e;
    @(posedge clk); #1;
    adsN = ads; advance = adv; extAddr = a;
    if (!ads) begin mBase = a; mBeat = 2'd0; end
    else if (adv) mBeat = mBeat + 2'd1;
    e.addr = {mBase[AW-1:2], refOfs(mBase[1:0], mBeat, modeInterleave)};
    e.beat = mBeat;
    e.tag  = tag;
    e.due  = cycle + 1;
    q.push_back(e);
  endtask

  // Monitor: compare once the result is due.
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due <= cycle) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, e.addr, e.beat);
    end
  end

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", '0, 2'd0);
    @(posedge clk); #1 rstN = 1'b1;

    for (int m = 0; m < 2; m++) begin
      drain();
      modeInterleave = m[0];
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] a;
        a = {AW'(17'h0A5C3 + 17'(s * 4099 + m * 777)), 2'b00} | AW'(s);
        drive(1'b0, 1'b0, a, "R2 load");
        drive(1'b1, 1'b1, '0, m ? "R7 R3 beat1" : "R6 R3 beat1");
        drive(1'b1, 1'b0, '1, "R4 hold");
        drive(1'b1, 1'b1, '0, m ? "R7 R5 beat2" : "R6 R5 beat2");
        drive(1'b1, 1'b1, '0, m ? "R7 beat3" : "R6 beat3");
        drive(1'b1, 1'b1, '0, "R8 wrap");
        drive(1'b1, 1'b1, '0, "R8 repeat");
      end
      // Abort mid-burst with advance also high.
      drive(1'b0, 1'b0, 19'h12345, "R2 load");
      drive(1'b1, 1'b1, '0, "R3 step");
      drive(1'b0, 1'b1, 19'h7FFF2, "R9 abort");
      drive(1'b1, 1'b1, '0, m ? "R9 R7 after abort" : "R9 R6 after abort");
      drive(1'b1, 1'b0, '0, "R4 hold");
    end
    drain();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule